// File: doc/BRIEF.md
# Sequential Mask/Value Trigger Unit

This block decides when a 32-channel logic capture engine starts recording. It holds a short chain of trigger stages. Each stage has a channel mask, an expected level pattern and a configuration word. The unit walks the chain one stage at a time. On each cycle where a sample is offered, the current stage compares the masked sample channels against its masked pattern. A hit moves the unit on to the next stage. When a stage carrying the start flag hits, the unit emits a single-cycle start pulse. It then stays in a fired state until it is armed again.

Software programs the stages through a write port keyed by an 8-bit opcode. Each register kind has its own base opcode, and consecutive stages sit four opcodes apart. Writes always go into a staging copy of the registers. Pulsing the arm input copies the staged registers into the working set, returns the chain to stage 0 and starts matching. A trigger that fires at once is built by giving stage 0 a zero mask and the start flag.

Top module: `stage_trigger_seq`

## Requirements
- R1: After reset the unit is idle: `armed`=0, `triggered`=0, `start_pulse`=0, `stage_idx`=0, and every staged and working mask, pattern and start flag is zero.
- R2: A write with `wr_en`=1 updates the staged mask of stage s when `wr_op` = 8'hC0+4s, the staged pattern when `wr_op` = 8'hC1+4s, and the staged configuration when `wr_op` = 8'hC2+4s. Every other opcode changes nothing.
- R3: A stage hits on a sample exactly when, for every channel whose mask bit is 1, the sample bit equals the pattern bit. A pattern bit of 1 requires high and a pattern bit of 0 requires low. Channels with a mask bit of 0 are not compared.
- R4: While armed, the current stage is judged only on cycles with `sample_en`=1. A hit on a stage without the start flag advances `stage_idx` by one. A hit on the last stage without the start flag leaves `stage_idx` unchanged. A miss, or `sample_en`=0, leaves `stage_idx` unchanged.
- R5: The start flag of a stage is bit 27 of its configuration word (the top byte). When the current stage hits and its flag is set, `start_pulse` is 1 for exactly the one cycle after the edge that took the sample. In that same cycle `triggered` becomes 1 and `armed` becomes 0.
- R6: Once triggered, further samples cause no pulse and no change of `stage_idx`, until the next arm.
- R7: Pulsing `arm` for one cycle makes the unit armed at stage 0 with `triggered`=0 after that edge. A sample offered in the arm cycle is not judged.
- R8: The working registers are loaded from the staged copy only at an arm edge. A write made while armed has no effect on matching until the next arm. A write made in the same cycle as `arm` is not part of that load.
- R9: A stage whose mask is zero hits on the first sample offered to it. With stage 0 set up this way and carrying the start flag, the first sample after arming produces the start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Load staged registers, return to stage 0, begin matching |
| wr_en | input | 1 | Register write strobe |
| wr_op | input | 8 | Write opcode selecting stage and register kind |
| wr_data | input | 32 | Write data |
| sample_en | input | 1 | A sample is offered this cycle |
| sample | input | 32 | Channel levels |
| start_pulse | output | 1 | One-cycle capture start |
| armed | output | 1 | Chain is matching |
| triggered | output | 1 | Chain has fired and waits for the next arm |
| stage_idx | output | 2 | Current stage of the chain |

## Verification
Two functions can fall in the same cycle. The first is an arm with a register write. The staged write lands at that edge, while the working copy is loaded from the value the staged copy held before the edge. The bench issues a write and an arm together and then offers samples that match only one of the two patterns. The stage progress and the pulse show which pattern was loaded. The same holds for an arm together with a matching sample, which must not advance the chain. The random phase hits both collisions often, because arm, writes and samples are drawn independently each cycle.

// File: rtl/trig_pkg.sv
package trig_pkg;
   typedef enum logic [1:0] {
      TRG_IDLE  = 2'd0,
      TRG_RUN   = 2'd1,
      TRG_FIRED = 2'd2
   } trg_state_e;
endpackage

// File: rtl/trig_stage_regs.sv
module trig_stage_regs #(
   parameter int          N_STAGES  = 4,
   parameter int          CH_W      = 32,
   parameter int          OPC_W     = 8,
   parameter int          CFG_W     = 32,
   parameter logic [7:0]  OP_MASK   = 8'hC0,
   parameter logic [7:0]  OP_VALUE  = 8'hC1,
   parameter logic [7:0]  OP_CFG    = 8'hC2,
   parameter int          OP_STRIDE = 4,
   parameter int          START_BIT = 27
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           load,
   input  logic                           wr_en,
   input  logic [OPC_W-1:0]               wr_op,
   input  logic [CFG_W-1:0]               wr_data,
   output logic [N_STAGES-1:0][CH_W-1:0]  act_mask,
   output logic [N_STAGES-1:0][CH_W-1:0]  act_val,
   output logic [N_STAGES-1:0]            act_start
);
   logic [N_STAGES-1:0][CH_W-1:0] stg_mask;
   logic [N_STAGES-1:0][CH_W-1:0] stg_val;
   logic [N_STAGES-1:0]           stg_start;

   for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
      localparam logic [OPC_W-1:0] MY_MASK  = OPC_W'(int'(OP_MASK)  + s * OP_STRIDE);
      localparam logic [OPC_W-1:0] MY_VALUE = OPC_W'(int'(OP_VALUE) + s * OP_STRIDE);
      localparam logic [OPC_W-1:0] MY_CFG   = OPC_W'(int'(OP_CFG)   + s * OP_STRIDE);

      logic hit_mask, hit_val, hit_cfg;
      assign hit_mask = wr_en && (wr_op == MY_MASK);
      assign hit_val  = wr_en && (wr_op == MY_VALUE);
      assign hit_cfg  = wr_en && (wr_op == MY_CFG);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stg_mask[s]  <= '0;
            stg_val[s]   <= '0;
            stg_start[s] <= 1'b0;
         end else begin
            if (hit_mask) stg_mask[s]  <= wr_data[CH_W-1:0];
            if (hit_val)  stg_val[s]   <= wr_data[CH_W-1:0];
            if (hit_cfg)  stg_start[s] <= wr_data[START_BIT];
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            act_mask[s]  <= '0;
            act_val[s]   <= '0;
            act_start[s] <= 1'b0;
         end else if (load) begin
            act_mask[s]  <= stg_mask[s];
            act_val[s]   <= stg_val[s];
            act_start[s] <= stg_start[s];
         end
      end
   end
endmodule

// File: rtl/trig_stage_match.sv
module trig_stage_match #(
   parameter int N_STAGES = 4,
   parameter int CH_W     = 32
) (
   input  logic [CH_W-1:0]                sample,
   input  logic [N_STAGES-1:0][CH_W-1:0]  act_mask,
   input  logic [N_STAGES-1:0][CH_W-1:0]  act_val,
   output logic [N_STAGES-1:0]            hit
);
   for (genvar s = 0; s < N_STAGES; s++) begin : g_cmp
      logic [CH_W-1:0] diff;
      assign diff   = (sample ^ act_val[s]) & act_mask[s];
      assign hit[s] = ~|diff;
   end
endmodule

// File: rtl/trig_seq_fsm.sv
module trig_seq_fsm
   import trig_pkg::*;
#(
   parameter int N_STAGES = 4,
   localparam int IDX_W   = $clog2(N_STAGES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 arm,
   input  logic                 sample_en,
   input  logic [N_STAGES-1:0]  hit,
   input  logic [N_STAGES-1:0]  start_flag,
   output logic [IDX_W-1:0]     stage_idx,
   output logic                 armed,
   output logic                 triggered,
   output logic                 start_pulse
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(N_STAGES - 1);

   trg_state_e      state_q;
   logic [IDX_W-1:0] stage_q;
   logic            pulse_q;
   logic            cur_hit, cur_start;

   assign cur_hit   = hit[stage_q];
   assign cur_start = start_flag[stage_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= TRG_IDLE;
         stage_q <= '0;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= 1'b0;
         if (arm) begin
            state_q <= TRG_RUN;
            stage_q <= '0;
         end else if (state_q == TRG_RUN && sample_en && cur_hit) begin
            if (cur_start) begin
               state_q <= TRG_FIRED;
               pulse_q <= 1'b1;
            end else if (stage_q != LAST) begin
               stage_q <= stage_q + 1'b1;
            end
         end
      end
   end

   assign stage_idx   = stage_q;
   assign armed       = (state_q == TRG_RUN);
   assign triggered   = (state_q == TRG_FIRED);
   assign start_pulse = pulse_q;
endmodule

// File: rtl/stage_trigger_seq.sv
module stage_trigger_seq #(
   parameter int          N_STAGES  = 4,
   parameter int          CH_W      = 32,
   parameter int          OPC_W     = 8,
   parameter int          CFG_W     = 32,
   parameter logic [7:0]  OP_MASK   = 8'hC0,
   parameter logic [7:0]  OP_VALUE  = 8'hC1,
   parameter logic [7:0]  OP_CFG    = 8'hC2,
   parameter int          OP_STRIDE = 4,
   parameter int          START_BIT = 27,
   localparam int         IDX_W     = $clog2(N_STAGES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  logic              wr_en,
   input  logic [OPC_W-1:0]  wr_op,
   input  logic [CFG_W-1:0]  wr_data,
   input  logic              sample_en,
   input  logic [CH_W-1:0]   sample,
   output logic              start_pulse,
   output logic              armed,
   output logic              triggered,
   output logic [IDX_W-1:0]  stage_idx
);
   if (N_STAGES < 2 || N_STAGES > 16) begin : g_bad_stages
      $error("N_STAGES must lie in 2..16");
   end
   if (CH_W > CFG_W) begin : g_bad_width
      $error("CH_W must not exceed CFG_W");
   end
   if (START_BIT >= CFG_W) begin : g_bad_flag
      $error("START_BIT outside configuration word");
   end
   if (int'(OP_CFG) + (N_STAGES - 1) * OP_STRIDE >= (1 << OPC_W)) begin : g_bad_opc
      $error("opcode range exceeds OPC_W");
   end

   logic [N_STAGES-1:0][CH_W-1:0] act_mask;
   logic [N_STAGES-1:0][CH_W-1:0] act_val;
   logic [N_STAGES-1:0]           act_start;
   logic [N_STAGES-1:0]           hit;

   trig_stage_regs #(
      .N_STAGES(N_STAGES), .CH_W(CH_W), .OPC_W(OPC_W), .CFG_W(CFG_W),
      .OP_MASK(OP_MASK), .OP_VALUE(OP_VALUE), .OP_CFG(OP_CFG),
      .OP_STRIDE(OP_STRIDE), .START_BIT(START_BIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .load(arm),
      .wr_en(wr_en), .wr_op(wr_op), .wr_data(wr_data),
      .act_mask(act_mask), .act_val(act_val), .act_start(act_start)
   );

   trig_stage_match #(.N_STAGES(N_STAGES), .CH_W(CH_W)) u_match (
      .sample(sample), .act_mask(act_mask), .act_val(act_val), .hit(hit)
   );

   trig_seq_fsm #(.N_STAGES(N_STAGES)) u_fsm (
      .clk(clk), .rst_n(rst_n), .arm(arm), .sample_en(sample_en),
      .hit(hit), .start_flag(act_start),
      .stage_idx(stage_idx), .armed(armed), .triggered(triggered),
      .start_pulse(start_pulse)
   );
endmodule

// File: rtl/trig_checker.sv
module trig_checker #(
   parameter int N_STAGES = 4,
   localparam int IDX_W   = $clog2(N_STAGES)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             arm,
   input logic             sample_en,
   input logic             start_pulse,
   input logic             armed,
   input logic             triggered,
   input logic [IDX_W-1:0] stage_idx
);
   // R5: pulse lasts one cycle
   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |=> !start_pulse);
   // R5: pulse coincides with the fired state
   a_r5_pulse_fired: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> (triggered && !armed));
   // R6: no pulse while staying fired
   a_r6_quiet_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
      (triggered && !arm) |=> (!start_pulse && triggered && $stable(stage_idx)));
   // R7: arm restarts the chain
   a_r7_arm_restart: assert property (@(posedge clk) disable iff (!rst_n)
      arm |=> (armed && !triggered && stage_idx == '0 && !start_pulse));
   // R4: no progress without a sample
   a_r4_hold_no_sample: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !arm && !sample_en) |=> (armed && $stable(stage_idx)));
   // R1: states are exclusive
   a_r1_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(armed && triggered));
endmodule

bind stage_trigger_seq trig_checker #(.N_STAGES(N_STAGES)) u_chk (
   .clk(clk), .rst_n(rst_n), .arm(arm), .sample_en(sample_en),
   .start_pulse(start_pulse), .armed(armed), .triggered(triggered),
   .stage_idx(stage_idx)
);

// File: tb/stage_trigger_seq_tb.sv
module stage_trigger_seq_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic arm = 1'b0, wr_en = 1'b0, sample_en = 1'b0;
   logic [7:0]  wr_op = '0;
   logic [31:0] wr_data = '0, sample = '0;
   logic start_pulse, armed, triggered;
   logic [1:0] stage_idx;

   int n_chk = 0, n_err = 0;
   bit done = 0;

   // bench model
   logic [31:0] sm [4], sv [4], am [4], av [4];
   bit ss [4], as_ [4];
   int m_st = 0, m_stg = 0;
   bit m_pulse = 0;

   always #4 clk = ~clk;

   stage_trigger_seq u_dut (
      .clk(clk), .rst_n(rst_n), .arm(arm), .wr_en(wr_en), .wr_op(wr_op),
      .wr_data(wr_data), .sample_en(sample_en), .sample(sample),
      .start_pulse(start_pulse), .armed(armed), .triggered(triggered),
      .stage_idx(stage_idx)
   );

   function automatic bit stage_hits(logic [31:0] s, logic [31:0] m, logic [31:0] v);
      for (int b = 0; b < 32; b++)
         if (m[b] && (s[b] !== v[b])) return 1'b0;
      return 1'b1;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 4; i++) begin
         sm[i] = 0; sv[i] = 0; am[i] = 0; av[i] = 0; ss[i] = 0; as_[i] = 0;
      end
      m_st = 0; m_stg = 0; m_pulse = 0;
   endtask

   task automatic model_edge();
      m_pulse = 0;
      if (arm) begin
         for (int i = 0; i < 4; i++) begin am[i] = sm[i]; av[i] = sv[i]; as_[i] = ss[i]; end
         m_st = 1; m_stg = 0;
      end else if (m_st == 1 && sample_en && stage_hits(sample, am[m_stg], av[m_stg])) begin
         if (as_[m_stg]) begin m_st = 2; m_pulse = 1; end
         else if (m_stg < 3) m_stg++;
      end
      if (wr_en) begin
         for (int i = 0; i < 4; i++) begin
            if (wr_op == 8'hC0 + 8'(4*i)) sm[i] = wr_data;
            if (wr_op == 8'hC1 + 8'(4*i)) sv[i] = wr_data;
            if (wr_op == 8'hC2 + 8'(4*i)) ss[i] = wr_data[27];
         end
      end
   endtask

   task automatic check(string req);
      logic [4:0] act, exp;
      act = {start_pulse, armed, triggered, stage_idx};
      exp = {m_pulse, (m_st == 1), (m_st == 2), 2'(m_stg)};
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: {pulse,armed,trig,stage} actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic step(bit a, bit we, logic [7:0] op, logic [31:0] d,
                       bit se, logic [31:0] s, string req);
      @(negedge clk);
      arm = a; wr_en = we; wr_op = op; wr_data = d; sample_en = se; sample = s;
      @(posedge clk);
      model_edge();
      #1;
      check(req);
   endtask

   task automatic wr(logic [7:0] op, logic [31:0] d, string req);
      step(0, 1, op, d, 0, 32'h0, req);
   endtask

   task automatic smp(logic [31:0] s, string req);
      step(0, 0, 8'h00, 32'h0, 1, s, req);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(posedge clk);
      #1; check("R1 reset state");
      @(negedge clk); rst_n = 1'b1;

      // R1: arming right after reset loads zero masks, no start flags: hit but no pulse
      step(1, 0, 0, 0, 0, 0, "R7 arm after reset");
      smp(32'hFFFF_FFFF, "R1 cleared regs advance");
      smp(32'h0, "R1 cleared regs advance");
      smp(32'h0, "R4 last stage holds");
      smp(32'h0, "R4 last stage holds");

      // R9 immediate trigger
      wr(8'hC0, 32'h0, "R2 mask write");
      wr(8'hC2, 32'h0800_0000, "R2 cfg write start");
      step(1, 0, 0, 0, 0, 0, "R7 arm");
      smp(32'h1234_5678, "R9 zero mask fires at once");
      smp(32'h1234_5678, "R6 no second pulse");
      smp(32'h0, "R6 stays fired");

      // chain of 3 stages
      wr(8'hC0, 32'h0000_00FF, "R2"); wr(8'hC1, 32'h0000_0012, "R2");
      wr(8'hC2, 32'h0000_0000, "R2");
      wr(8'hC4, 32'h0000_FF00, "R2"); wr(8'hC5, 32'h0000_3400, "R2");
      wr(8'hC8, 32'h8000_0001, "R2"); wr(8'hC9, 32'h8000_0000, "R2");
      wr(8'hCA, 32'h0800_0000, "R2");
      wr(8'hC3, 32'hFFFF_FFFF, "R2 unused opcode ignored");
      step(1, 0, 0, 0, 1, 32'h12, "R7 sample in arm cycle not judged");
      smp(32'h13, "R3 mismatch holds");
      step(0, 0, 0, 0, 0, 32'h12, "R4 no sample_en holds");
      smp(32'hABCD_EF12, "R3 masked match advances");
      smp(32'h0000_3500, "R3 low bit mismatch");
      smp(32'h0000_3400, "R4 stage1 advances");
      // R8: change stage 2 while armed
      wr(8'hC9, 32'h0000_0001, "R8 write while armed");
      smp(32'h0000_0001, "R8 new pattern not yet live");
      smp(32'h8000_0000, "R5 start stage fires");
      smp(32'h8000_0000, "R6 quiet after fire");

      // R8 collision: write in arm cycle excluded from load
      step(1, 1, 8'hC1, 32'h0000_0099, 0, 0, "R8 arm with write");
      smp(32'h0000_0099, "R8 colliding write not loaded");
      smp(32'h0000_0012, "R8 old pattern live");
      step(1, 0, 0, 0, 0, 0, "R7 rearm");
      smp(32'h0000_0099, "R8 write live after next arm");

      // random phase
      for (int k = 0; k < 4000; k++) begin
         bit a, we, se;
         logic [7:0] op;
         logic [31:0] d, s;
         a  = ($urandom_range(0, 24) == 0);
         we = ($urandom_range(0, 3) == 0);
         op = ($urandom_range(0, 5) == 0) ? 8'($urandom) : 8'hC0 + 8'($urandom_range(0, 11));
         d  = $urandom & $urandom & $urandom;
         if ($urandom_range(0, 1) == 0) d[27] = 1'b0;
         se = ($urandom_range(0, 2) != 0);
         s  = $urandom & $urandom;
         step(a, we, op, d, se, s, "R3 R4 R5 R6 R7 R8 random");
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule